// File: doc/BRIEF.md
# Bit-Serial Swap Link

This block is a synchronous point-to-point channel between two processing elements that run on one clock. Each end holds a parallel-load shift register. When its owner pulses `start`, the end loads the word to send, raises its link select and its request, and waits. A rendezvous term is true only while both ends request. Both ends see it in the same cycle, drop their requests, and shift together for a fixed number of clocks. The serial output of each end feeds the serial input of the other, so the two registers form one ring. When the shifting ends, each register holds the word the peer loaded.

The exchange is symmetric. There is no sending or receiving side, so one link does the job of an input and an output channel at once. The top module joins two ends, called A and B. Each end's owner sees the same narrow interface: a start strobe, a word to send, a done pulse and the received word.

Top module: `xlink_pair`

## Requirements
- R1: After reset both done outputs are low and both received words are zero.
- R2: A start seen while an end is idle loads that end's word. The received word of that end then shows the loaded word unchanged, and its done stays low, for as long as the peer has not requested.
- R3: When an exchange completes, A's received word equals the word B loaded, and B's received word equals the word A loaded. This holds for every bit pattern.
- R4: Done pulses high for exactly one cycle, at both ends in the same cycle. The pulse comes W+1 cycles after the clock edge at which the later of the two starts is sampled, where W is the word width (32 by default). Starts sampled at the same edge count the same way.
- R5: A start that arrives while an end is waiting or shifting is ignored. The word presented with it is not captured, and the exchange result is unchanged.
- R6: After done, each received word holds its value until that end accepts its next start.
- R7: Either end may request first, and the result is the same swap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ends |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| a_start | input | 1 | End A request strobe |
| a_word | input | 32 | Word that end A sends |
| a_done | output | 1 | End A exchange-complete pulse |
| a_rx | output | 32 | End A register contents (the received word after done) |
| b_start | input | 1 | End B request strobe |
| b_word | input | 32 | Word that end B sends |
| b_done | output | 1 | End B exchange-complete pulse |
| b_rx | output | 32 | End B register contents (the received word after done) |

## Verification
The swap is tried with several pairs of words: opposite patterns (all ones against zero), two different alternating patterns, and two equal words. A bit reversal or a stuck ring wire corrupts the opposite patterns, and an off-by-one shift count shows up in the alternating ones. The starts are issued in the same cycle, with A leading by several cycles, and with B leading. These cases separate a correct rendezvous from one that lets a single side shift early, and they confirm that done is timed from the later request. A stray start during shifting and a long idle stretch after done check that busy requests are ignored and that results are held.

// File: rtl/xlink_pkg.sv
package xlink_pkg;
  typedef enum logic [1:0] {
    XL_IDLE  = 2'd0,
    XL_REQ   = 2'd1,
    XL_SHIFT = 2'd2
  } xl_state_e;
endpackage

// File: rtl/xlink_rst_sync.sv
module xlink_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_out_n = sync_q;
endmodule

// File: rtl/xlink_ctrl.sv
module xlink_ctrl
  import xlink_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ready_i,
  output logic sel_o,
  output logic sync_o,
  output logic load_o,
  output logic shift_o,
  output logic done_o
);
  localparam int CW = $clog2(W + 1);

  xl_state_e       st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            done_q, done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    case (st_q)
      XL_IDLE: begin
        if (start) st_d = XL_REQ;
      end
      XL_REQ: begin
        if (ready_i) begin
          st_d  = XL_SHIFT;
          cnt_d = CW'(W);
        end
      end
      XL_SHIFT: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          st_d   = XL_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = XL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XL_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign load_o  = (st_q == XL_IDLE) && start;
  assign shift_o = (st_q == XL_SHIFT);
  assign sel_o   = (st_q != XL_IDLE);
  assign sync_o  = (st_q == XL_REQ);
  assign done_o  = done_q;

  AST_SYNC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && ready_i) |=> (!sync_o && shift_o)); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(W)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R4
  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_o && start) |=> (st_q != XL_REQ)); // R5
endmodule

// File: rtl/xlink_shreg.sv
module xlink_shreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] par_d,
  input  logic         ser_i,
  output logic         ser_o,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_d;

  always_comb begin
    q_d = q_r;
    if (load)       q_d = par_d;
    else if (shift) q_d = {ser_i, q_r[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else if (load || shift) q_r <= q_d;
  end

  assign ser_o = q_r[0];
  assign q     = q_r;

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(q_r)); // R6
endmodule

// File: rtl/xlink_end.sv
module xlink_end #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] word_i,
  output logic         done,
  output logic [W-1:0] rx,
  output logic         sel_o,
  output logic         sync_o,
  input  logic         ready_i,
  output logic         ser_o,
  input  logic         ser_i
);
  logic load_w, shift_w;

  xlink_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .ready_i (ready_i),
    .sel_o   (sel_o),
    .sync_o  (sync_o),
    .load_o  (load_w),
    .shift_o (shift_w),
    .done_o  (done)
  );

  xlink_shreg #(.W(W)) u_sr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_w),
    .shift (shift_w),
    .par_d (word_i),
    .ser_i (ser_i),
    .ser_o (ser_o),
    .q     (rx)
  );
endmodule

// File: rtl/xlink_pair.sv
module xlink_pair #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_start,
  input  logic [W-1:0] a_word,
  output logic         a_done,
  output logic [W-1:0] a_rx,
  input  logic         b_start,
  input  logic [W-1:0] b_word,
  output logic         b_done,
  output logic [W-1:0] b_rx
);
  logic rst_s_n;
  logic a_sel, a_sync, a_ser;
  logic b_sel, b_sync, b_ser;
  logic ready;

  xlink_rst_sync u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_s_n)
  );

  assign ready = a_sel && a_sync && b_sel && b_sync;

  xlink_end #(.W(W)) u_a (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start   (a_start),
    .word_i  (a_word),
    .done    (a_done),
    .rx      (a_rx),
    .sel_o   (a_sel),
    .sync_o  (a_sync),
    .ready_i (ready),
    .ser_o   (a_ser),
    .ser_i   (b_ser & b_sel)
  );

  xlink_end #(.W(W)) u_b (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start   (b_start),
    .word_i  (b_word),
    .done    (b_done),
    .rx      (b_rx),
    .sel_o   (b_sel),
    .sync_o  (b_sync),
    .ready_i (ready),
    .ser_o   (b_ser),
    .ser_i   (a_ser & a_sel)
  );

  AST_DONE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_s_n)
    a_done == b_done); // R4
  AST_ONE_SIDE_WAITS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (a_sync && !b_sel) |=> $stable(a_rx)); // R2
endmodule

// File: tb/xlink_pair_test.sv
module xlink_pair_test;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic         a_start, b_start;
  logic [W-1:0] a_word, b_word;
  logic         a_done, b_done;
  logic [W-1:0] a_rx, b_rx;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  xlink_pair #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_start(a_start), .a_word(a_word), .a_done(a_done), .a_rx(a_rx),
    .b_start(b_start), .b_word(b_word), .b_done(b_done), .b_rx(b_rx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 a_done", {31'd0, a_done}, '0);
    chk("R1 b_done", {31'd0, b_done}, '0);
    chk("R1 a_rx", a_rx, '0);
    chk("R1 b_rx", b_rx, '0);
  endtask

  // Exchange with start offsets da, db (cycles); checks R2, R3, R4, R6, R7.
  task automatic t_swap(input logic [W-1:0] va, input logic [W-1:0] vb,
                        input int da, input int db);
    int later;
    later = (da > db) ? da : db;
    a_word = va;
    b_word = vb;
    for (int t = 0; t <= later; t++) begin
      a_start = (t == da);
      b_start = (t == db);
      if (t > 0 && t > da && t <= db) begin
        chk("R2 waiting a_rx", a_rx, va);
        chk("R2 waiting a_done", {31'd0, a_done}, '0);
      end
      if (t > 0 && t > db && t <= da) begin
        chk("R7 waiting b_rx", b_rx, vb);
        chk("R7 waiting b_done", {31'd0, b_done}, '0);
      end
      @(negedge clk);
    end
    a_start = 1'b0;
    b_start = 1'b0;
    for (int i = 0; i <= W; i++) begin
      @(negedge clk);
      if (i < W) begin
        if (a_done || b_done) chk("R4 early done", {30'd0, a_done, b_done}, '0);
      end else begin
        chk("R4 a_done on time", {31'd0, a_done}, 32'd1);
        chk("R4 b_done on time", {31'd0, b_done}, 32'd1);
        chk("R3 a_rx gets b word", a_rx, vb);
        chk("R3 b_rx gets a word", b_rx, va);
      end
    end
    @(negedge clk);
    chk("R4 done one cycle", {30'd0, a_done, b_done}, '0);
    for (int k = 0; k < 4; k++) @(negedge clk);
    chk("R6 a_rx held", a_rx, vb);
    chk("R6 b_rx held", b_rx, va);
  endtask

  // Start pulsed with a new word while shifting must be ignored (R5).
  task automatic t_busy_start;
    a_word = 32'hCAFE_0001;
    b_word = 32'h0BAD_F00D;
    a_start = 1'b1;
    b_start = 1'b1;
    @(negedge clk);
    a_start = 1'b0;
    b_start = 1'b0;
    for (int k = 0; k < 5; k++) @(negedge clk);
    a_word  = 32'h1234_5678;
    a_start = 1'b1;
    @(negedge clk);
    a_start = 1'b0;
    for (int k = 0; k < W; k++) @(negedge clk);
    chk("R5 b_rx keeps first a word", b_rx, 32'hCAFE_0001);
    chk("R5 a_rx gets b word", a_rx, 32'h0BAD_F00D);
    for (int k = 0; k < 6; k++) @(negedge clk);
    chk("R5 no new exchange a_done", {31'd0, a_done}, '0);
    chk("R5 a_rx unchanged after stray start", a_rx, 32'h0BAD_F00D);
  endtask

  initial begin
    rst_n   = 1'b0;
    a_start = 1'b0;
    b_start = 1'b0;
    a_word  = '0;
    b_word  = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_swap(32'hFFFF_FFFF, 32'h0000_0000, 0, 0);
    t_swap(32'hA5A5_5A5A, 32'h3C3C_C3C3, 0, 6);
    t_swap(32'h8000_0001, 32'h7FFF_FFFE, 9, 2);
    t_swap(32'h1357_9BDF, 32'h1357_9BDF, 1, 0);
    t_busy_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule